// File: doc/BRIEF.md
# Complex Baseband Frequency Shifter

This block moves a complex baseband stream up or down in frequency by a programmable amount. A 32-bit phase accumulator advances by a tuning word once for each accepted sample. The top bits of the accumulator index a sine table, and every incoming I/Q pair is rotated by the resulting complex exponential. The rotated pair is rounded back to the input width, so the stage has unit gain. The tuning word is the desired shift as a fraction of the sample rate, scaled by 2^32. For example, a +1 MHz shift at a 38.4 MHz sample rate uses 111848107. A word above 2^31 gives a downward shift.

Samples enter and leave on valid/ready streams. The pipeline advances as a whole whenever its output register is empty or being taken. When the output holds a sample that the sink refuses, every stage freezes and `s_ready` drops in the same cycle. A source may hold `s_valid` high while `s_ready` is low: nothing is taken, and the sample is accepted on the first edge where both are high. The tuning word is a plain control input. It is sampled only on an accepting edge, and no handshake protects it.

Top module: `fshift_top`

## Requirements
- R1: After reset, `m_valid` is low and `s_ready` is high, and the first accepted sample is rotated with phase zero (accumulator cleared).
- R2: The phase used for the n-th accepted sample is the sum, modulo 2^32, of the tuning words sampled with samples 0..n-1. The accumulator changes only on an accepting edge (`s_valid && s_ready`).
- R3: The tuning word present on an accepting edge is added after that sample's phase is captured. A new word therefore first affects the next accepted sample, and changing the word never resets the phase.
- R4: With table index k = phase[31:22], the sine value is round(2047·sin(2π(k+0.5)/1024)) and the cosine value is the sine value at index (k+256) mod 1024. Rounding is half away from zero, and the amplitudes are 12-bit two's complement.
- R5: The output is I' = I·cos − Q·sin and Q' = I·sin + Q·cos. Each full-precision sum is rounded by adding 1024 and shifting arithmetically right by 11, on 12-bit two's complement samples.
- R6: A rounded result above 2047 is output as 2047, and one below −2048 is output as −2048.
- R7: With `m_ready` held high, a sample accepted on edge A appears on `m_i`/`m_q` with `m_valid` high right after edge A+3. Outputs keep input order, and exactly one output is produced per accepted sample.
- R8: While `m_valid` is high and `m_ready` is low, `s_ready` is low, `m_valid`, `m_i` and `m_q` stay unchanged, and no sample is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| freq_word | input | 32 | Phase increment per accepted sample |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can accept a sample this cycle |
| s_i | input | 12 | Input in-phase sample, two's complement |
| s_q | input | 12 | Input quadrature sample, two's complement |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Sink accepts the output sample |
| m_i | output | 12 | Rotated in-phase sample |
| m_q | output | 12 | Rotated quadrature sample |

## Verification
The hardest situation to reach is a change of tuning word that lands while the pipeline is frozen by back-pressure. The new word must still be charged to the sample that is finally accepted, not to the cycle in which it appeared. The stimulus reaches this case in a phase where the sink refuses about one cycle in four at random. During that phase the source changes the word and the sample together, inserts random gaps and holds `s_valid` through refusals. A scoreboard tracks phase only on real acceptances, so any early, late or repeated accumulation shows up as a miscompare. A separate fixed-rate phase, in which the sink is always ready, checks the exact three-cycle latency. A full-scale rotation at one-eighth of a turn per sample drives the sums past the 12-bit range to reach both saturation limits.

// File: rtl/fshift_pkg.sv
package fshift_pkg;

  localparam int SAMPLE_W = 12;
  localparam int PHASE_W  = 32;
  localparam int LUT_AW   = 10;
  localparam int PIPE_LAT = 3;

  localparam real TWO_PI = 6.283185307179586;

  // Magnitude of one quarter-wave entry, sampled half a step off the grid
  // so that the four quadrants mirror exactly onto the same entries.
  function automatic int quarter_sine(input int k, input int depth, input int amp);
    real ang;
    real v;
    ang = TWO_PI * (real'(k) + 0.5) / real'(4 * depth);
    v   = real'(amp) * $sin(ang);
    return $rtoi(v + 0.5);
  endfunction

endpackage

// File: rtl/fshift_nco.sv
// Input capture stage: registers the sample, latches the current phase
// index for it and then advances the accumulator by the tuning word.
module fshift_nco #(
  parameter int DW = 12,
  parameter int PW = 32,
  parameter int AW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 take,
  input  logic [PW-1:0]        word,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q,
  output logic [AW-1:0]        idx
);

  logic [PW-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      out_i <= '0;
      out_q <= '0;
      idx   <= '0;
    end else if (en && take) begin
      out_i <= in_i;
      out_q <= in_q;
      idx   <= acc_q[PW-1 -: AW];
      acc_q <= acc_q + word;
    end
  end

endmodule

// File: rtl/fshift_trig_lut.sv
// Registered sine/cosine lookup built on a quarter-wave table.
module fshift_trig_lut #(
  parameter int DW = 12,
  parameter int AW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [AW-1:0]        idx,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic signed [DW-1:0] sin_o,
  output logic signed [DW-1:0] cos_o,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);

  localparam int QD  = 1 << (AW - 2);
  localparam int AMP = (1 << (DW - 1)) - 1;

  logic [DW-2:0] qtab [QD];

  for (genvar k = 0; k < QD; k++) begin : g_tab
    localparam int VAL = fshift_pkg::quarter_sine(k, QD, AMP);
    assign qtab[k] = (DW-1)'(VAL);
  end

  // Lane 0 reads sine at idx, lane 1 reads it a quarter turn ahead (cosine).
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [AW-1:0]        a;
    logic [AW-3:0]        j;
    logic [DW-2:0]        mag;
    logic signed [DW-1:0] val;
    always_comb begin
      a   = idx + AW'(g * QD);
      j   = a[AW-2] ? ~a[AW-3:0] : a[AW-3:0];
      mag = qtab[j];
      val = a[AW-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_o <= '0;
      cos_o <= '0;
      out_i <= '0;
      out_q <= '0;
    end else if (en) begin
      sin_o <= g_lane[0].val;
      cos_o <= g_lane[1].val;
      out_i <= in_i;
      out_q <= in_q;
    end
  end

endmodule

// File: rtl/fshift_cmul.sv
// Two-stage complex multiply: four registered products, then
// sum, round half up and saturate back to DW bits.
module fshift_cmul #(
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] a_q,
  input  logic signed [DW-1:0] c,
  input  logic signed [DW-1:0] s,
  output logic signed [DW-1:0] y_i,
  output logic signed [DW-1:0] y_q
);

  localparam int PRW = 2 * DW;
  localparam int SW  = PRW + 1;
  localparam logic signed [SW-1:0] HALF = SW'(1 << (DW - 2));
  localparam logic signed [SW-1:0] HI   = SW'((1 << (DW - 1)) - 1);
  localparam logic signed [SW-1:0] LO   = -HI - SW'(1);

  logic signed [PRW-1:0] p_ic, p_qs, p_is, p_qc;
  logic signed [SW-1:0]  sum_i, sum_q;

  function automatic logic signed [DW-1:0] round_sat(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] r;
    r = (v + HALF) >>> (DW - 1);
    if (r > HI)      return DW'(HI);
    else if (r < LO) return DW'(LO);
    else             return DW'(r);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_ic <= '0;
      p_qs <= '0;
      p_is <= '0;
      p_qc <= '0;
    end else if (en) begin
      p_ic <= a_i * c;
      p_qs <= a_q * s;
      p_is <= a_i * s;
      p_qc <= a_q * c;
    end
  end

  always_comb begin
    sum_i = SW'(p_ic) - SW'(p_qs);
    sum_q = SW'(p_is) + SW'(p_qc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_i <= '0;
      y_q <= '0;
    end else if (en) begin
      y_i <= round_sat(sum_i);
      y_q <= round_sat(sum_q);
    end
  end

endmodule

// File: rtl/fshift_top.sv
module fshift_top
  import fshift_pkg::*;
#(
  parameter int DW = SAMPLE_W,
  parameter int PW = PHASE_W,
  parameter int AW = LUT_AW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PW-1:0]        freq_word,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic signed [DW-1:0] s_i,
  input  logic signed [DW-1:0] s_q,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic signed [DW-1:0] m_i,
  output logic signed [DW-1:0] m_q
);

  localparam int NSTG = PIPE_LAT + 1;

  logic                 adv;
  logic [NSTG-1:0]      vld;
  logic signed [DW-1:0] n_i, n_q, l_i, l_q, l_sin, l_cos;
  logic [AW-1:0]        n_idx;

  assign adv     = !vld[NSTG-1] || m_ready;
  assign s_ready = adv;
  assign m_valid = vld[NSTG-1];

  for (genvar k = 0; k < NSTG; k++) begin : g_vld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld[k] <= 1'b0;
      else if (adv) vld[k] <= (k == 0) ? s_valid : vld[(k == 0) ? 0 : k-1];
    end
  end

  fshift_nco #(.DW(DW), .PW(PW), .AW(AW)) u_nco (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .take  (s_valid),
    .word  (freq_word),
    .in_i  (s_i),
    .in_q  (s_q),
    .out_i (n_i),
    .out_q (n_q),
    .idx   (n_idx)
  );

  fshift_trig_lut #(.DW(DW), .AW(AW)) u_lut (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .idx   (n_idx),
    .in_i  (n_i),
    .in_q  (n_q),
    .sin_o (l_sin),
    .cos_o (l_cos),
    .out_i (l_i),
    .out_q (l_q)
  );

  fshift_cmul #(.DW(DW)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .a_i   (l_i),
    .a_q   (l_q),
    .c     (l_cos),
    .s     (l_sin),
    .y_i   (m_i),
    .y_q   (m_q)
  );

endmodule

// File: rtl/fshift_chk.sv
module fshift_chk #(
  parameter int DW = 12,
  parameter int PW = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [PW-1:0]        freq_word,
  input logic                 s_valid,
  input logic                 s_ready,
  input logic                 m_valid,
  input logic                 m_ready,
  input logic signed [DW-1:0] m_i,
  input logic signed [DW-1:0] m_q,
  input logic [PW-1:0]        acc
);

  logic       hs_in, hs_out;
  logic [2:0] inflight;

  assign hs_in  = s_valid && s_ready;
  assign hs_out = m_valid && m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + 3'(hs_in) - 3'(hs_out);
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!m_valid && s_ready && acc == '0));

  p_acc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_in |=> $stable(acc));

  p_acc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hs_in |=> (acc == $past(acc) + $past(freq_word)));

  p_inflight_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 3'd4);

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hs_in, 3) && $past(m_ready, 2) && $past(m_ready, 1) && m_ready) |=> m_valid);

  p_hold_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_i) && $stable(m_q)));

  p_no_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

endmodule

bind fshift_top fshift_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .freq_word (freq_word),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .m_i       (m_i),
  .m_q       (m_q),
  .acc       (u_nco.acc_q)
);

// File: tb/sim_fshift_top.sv
module sim_fshift_top;

  localparam int  PERIOD = 10;
  localparam real TAU    = 6.283185307179586;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] freq_word = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic signed [11:0] s_i = '0, s_q = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic signed [11:0] m_i, m_q;

  int checks = 0, fails = 0, cyc = 0, sat_hits = 0;
  bit bp_mode = 0, done = 0;
  string cur_req = "R1";
  logic [31:0] ph = '0;

  int    exp_i[$], exp_q[$], exp_c[$];
  bit    exp_l[$];
  string exp_r[$];

  bit held = 0;
  logic signed [11:0] hold_i, hold_q;

  fshift_top u0 (
    .clk(clk), .rst_n(rst_n), .freq_word(freq_word),
    .s_valid(s_valid), .s_ready(s_ready), .s_i(s_i), .s_q(s_q),
    .m_valid(m_valid), .m_ready(m_ready), .m_i(m_i), .m_q(m_q)
  );

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  always begin
    @(posedge clk);
    #1;
    m_ready = bp_mode ? ($urandom_range(3) != 0) : 1'b1;
  end

  // R4 table value, rounded half away from zero
  function automatic int lutv(input int k);
    real x;
    x = 2047.0 * $sin(TAU * (real'(k) + 0.5) / 1024.0);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  // R5 rounding and R6 saturation
  function automatic int rsat(input int v, inout int hits);
    int r;
    r = (v + 1024) >>> 11;
    if (r > 2047)  begin hits++; return 2047;  end
    if (r < -2048) begin hits++; return -2048; end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: called at a negedge, returns at a negedge
  task automatic send(input int i, input int q, input logic [31:0] w);
    int k, sv, cv;
    s_valid   = 1'b1;
    s_i       = 12'(i);
    s_q       = 12'(q);
    freq_word = w;
    while (!s_ready) @(negedge clk);
    k  = int'(ph[31:22]);
    sv = lutv(k);
    cv = lutv((k + 256) % 1024);
    exp_i.push_back(rsat(i * cv - q * sv, sat_hits));
    exp_q.push_back(rsat(i * sv + q * cv, sat_hits));
    exp_c.push_back(cyc + 1);
    exp_l.push_back(!bp_mode);
    exp_r.push_back(cur_req);
    ph = ph + w;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_i.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (held) begin
        check(m_valid && m_i == hold_i && m_q == hold_q, "R8", "held output I",
              int'(m_i), int'(hold_i));
      end
      held   = m_valid && !m_ready;
      hold_i = m_i;
      hold_q = m_q;
      if (m_valid && m_ready) begin
        if (exp_i.size() == 0) begin
          check(1'b0, "R7", "output with empty scoreboard", 1, 0);
        end else begin
          int ei, eq, ec;
          bit el;
          string er;
          ei = exp_i.pop_front();
          eq = exp_q.pop_front();
          ec = exp_c.pop_front();
          el = exp_l.pop_front();
          er = exp_r.pop_front();
          check(int'(m_i) == ei, er, "I sample", int'(m_i), ei);
          check(int'(m_q) == eq, er, "Q sample", int'(m_q), eq);
          if (el) check(cyc - ec == 3, "R7", "latency in cycles", cyc - ec, 3);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R7 watchdog expired: actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(m_valid == 1'b0, "R1", "m_valid after reset", int'(m_valid), 0);
    check(s_ready == 1'b1, "R1", "s_ready after reset", int'(s_ready), 1);

    // R1/R7: first sample uses phase zero, fixed latency
    cur_req = "R1";
    send(1000, -500, 32'd0);
    repeat (6) @(negedge clk);

    // R4/R5: table and product at several phases
    cur_req = "R4";
    for (int n = 0; n < 24; n++) send(700 - 60 * n, 37 * n - 400, 32'h0AB0_0000);
    cur_req = "R5";
    for (int n = 0; n < 12; n++) send((n % 2) ? -1 : 1, 1, 32'h1357_9BDF);
    drain();

    // R3: word changes mid-stream, no phase reset
    cur_req = "R3";
    for (int n = 0; n < 10; n++) send(1500, 300, 32'd111848107);
    for (int n = 0; n < 10; n++) send(-800, 1200, 32'h0800_0000);
    for (int n = 0; n < 10; n++) send(n * 150, -n * 90, (n % 2) ? 32'h4000_0000 : 32'h0100_0000);
    drain();

    // R2: downward shifts and accumulator wrap
    cur_req = "R2";
    for (int n = 0; n < 20; n++) send(1800, -900, 32'hF000_0000);
    for (int n = 0; n < 8;  n++) send(-1234, 567, 32'hFFFF_FFFF);
    for (int n = 0; n < 8;  n++) send(900, 900, 32'h8000_0001);
    drain();

    // R6: full-scale rotation pushes sums past the 12-bit range
    cur_req = "R6";
    sat_hits = 0;
    for (int n = 0; n < 16; n++) begin
      send(2047, -2048, 32'h2000_0000);
      send(-2048, -2048, 32'h2000_0000);
    end
    drain();
    check(sat_hits > 0, "R6", "saturating cases reached", sat_hits, 1);

    // R8: random back-pressure, gaps and word changes
    cur_req = "R8";
    bp_mode = 1;
    for (int n = 0; n < 300; n++) begin
      send($urandom_range(4095) - 2048, $urandom_range(4095) - 2048,
           (n % 17 == 0) ? $urandom : 32'd111848107);
      if ($urandom_range(3) == 0) repeat ($urandom_range(2) + 1) @(negedge clk);
    end
    drain();
    bp_mode = 0;
    repeat (10) @(negedge clk);
    check(exp_i.size() == 0, "R7", "pending outputs at end", exp_i.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule